// File: doc/BRIEF.md
# SRAM Array Access Strobe Sequencer

This block times the strobes of one SRAM array access, counted on a fast tick clock that runs many times per processor cycle. For each access it drives:

- the bitline precharge,
- the column read select,
- the wordline enable,
- the sense-amplifier precharge,
- the sense-amplifier enable,
- the write enable,
- the output-data latch strobe.

The order of these strobes is fixed. The widths of the timing windows are parameters counted in ticks. The storage cells, the analog sensing and the row decode are outside the block. The decode is seen only through a per-port row-ready input.

An access is accepted only when three things hold: a request is present, the decoded row is ready, and the port is idle.

- **Read.** The bitline precharge drops for one tick. The wordline and read select then rise and are held for the programmed bitline-differential wait. The sense amplifier then fires, and the wordline drops on the same tick. When the sense window closes, the bitline precharge restarts at once. This happens one tick before the output latch strobe, so the precharge of the next access overlaps the data hand-off.
- **Write.** The write enable pulses under the wordline. The write skips sensing and holds the precharge off for a non-overlap gap after the wordline falls.

The port count is a parameter. With two ports, each port has its own sequencer and its own strobe set. Two reads, or one read and one write, therefore proceed side by side in the same ticks.

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset, and whenever a port is idle, that port drives bitline precharge high, sense-amplifier precharge high, and wordline, read select, sense enable, write enable and output strobe low. Its busy output is low.
- R2: A port accepts a request at a clock edge only if, at that edge, three conditions hold: its request input is high, its row-ready input is high, and busy is low. Busy is high from the tick that follows acceptance.
- R3: In the first tick after acceptance, bitline precharge is low while wordline and read select are still low. Bitline precharge and wordline are never high in the same tick.
- R4: On a read, wordline and read select stay high for exactly SENSE_DLY ticks. Sense enable rises in the tick the wordline falls, and never earlier.
- R5: On a read, sense-amplifier precharge goes low in the same tick the wordline rises, which is before sense enable. It returns high when the port goes idle. On a write it stays high throughout.
- R6: On a read, sense enable stays high for SENSE_LEN ticks. In the tick after that, bitline precharge rises while the output strobe is still low. The output strobe is high for the single tick that follows. The port is idle after that, so a read keeps busy high for SENSE_DLY+SENSE_LEN+3 ticks.
- R7: On a write, write enable and wordline are high together for WRITE_LEN ticks, while read select and sense enable stay low. All strobes other than sense-amplifier precharge are then low for NONOVL_GAP ticks. After that the port is idle, so a write keeps busy high for WRITE_LEN+NONOVL_GAP+1 ticks.
- R8: With two ports, each port runs its own sequence. Simultaneous or staggered requests to the two ports, read/read or read/write, each produce exactly the single-port strobe timing.
- R9: At least NONOVL_GAP low-wordline ticks separate every fall of the wordline from the next rise of bitline precharge. A parameter set with SENSE_LEN below NONOVL_GAP, or with any window under one tick, is rejected by an assertion.
- R10: A request presented while the port is busy is ignored. The running access keeps its timing, and no second access follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_PORTS | Access request, one bit per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, sampled with the request |
| row_ready | input | NUM_PORTS | Decoded wordline is stable and may be fired |
| busy | output | NUM_PORTS | Port is running an access |
| bl_pre | output | NUM_PORTS | Bitline precharge enable |
| rd_sel | output | NUM_PORTS | Column read select |
| wl_en | output | NUM_PORTS | Wordline enable |
| sa_pre | output | NUM_PORTS | Sense-amplifier precharge / equalize |
| sa_en | output | NUM_PORTS | Sense-amplifier enable |
| wr_en | output | NUM_PORTS | Write driver enable |
| dout_stb | output | NUM_PORTS | Output data latch strobe |

## Verification
The sequencer is exercised with the following patterns, each of which separates a different class of fault:

- **Isolated reads and writes.** These pin down every window width and the exact tick of each edge.
- **A read followed immediately by a write.** This shows that the return to idle restores both precharges before the next access starts.
- **A request held without row-ready.** This separates the acceptance condition from the request alone.
- **A request held during a busy read.** This exposes any re-trigger or lengthening of the access.
- **Simultaneous and one-tick-staggered requests on both ports, as read/read and read/write pairs.** These reveal any sharing of state between the two sequencers.

The wordline-to-precharge gap is measured at the pins for every access.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_PREOFF  = 3'd1,
    PH_WORD    = 3'd2,
    PH_SENSE   = 3'd3,
    PH_RESTART = 3'd4,
    PH_LATCH   = 3'd5,
    PH_GAP     = 3'd6
  } phase_e;

  typedef struct packed {
    logic bl_pre;
    logic rd_sel;
    logic wl_en;
    logic sa_pre;
    logic sa_en;
    logic wr_en;
    logic dout_stb;
  } strobe_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..m (at least one)
  function automatic int cnt_width(input int m);
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // ticks with busy high for one read: preoff + wordline + sense + restart + latch
  function automatic int read_busy_ticks(input int sense_dly, input int sense_len);
    return 1 + sense_dly + sense_len + 1 + 1;
  endfunction

  // ticks with busy high for one write: preoff + wordline + gap
  function automatic int write_busy_ticks(input int write_len, input int gap);
    return 1 + write_len + gap;
  endfunction

endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0); // R4

endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
  import sram_seq_pkg::*;
(
  input  phase_e  phase,
  input  logic    op_wr,
  output strobe_t strb
);

  always_comb begin
    strb = '{bl_pre: 1'b0, rd_sel: 1'b0, wl_en: 1'b0, sa_pre: 1'b1,
             sa_en: 1'b0, wr_en: 1'b0, dout_stb: 1'b0};
    unique case (phase)
      PH_IDLE:    strb.bl_pre = 1'b1;
      PH_PREOFF:  ;
      PH_WORD: begin
        strb.wl_en  = 1'b1;
        strb.rd_sel = !op_wr;
        strb.wr_en  = op_wr;
        strb.sa_pre = op_wr;
      end
      PH_SENSE: begin
        strb.sa_pre = 1'b0;
        strb.sa_en  = 1'b1;
      end
      PH_RESTART: begin
        strb.sa_pre = 1'b0;
        strb.bl_pre = 1'b1;
      end
      PH_LATCH: begin
        strb.sa_pre   = 1'b0;
        strb.bl_pre   = 1'b1;
        strb.dout_stb = 1'b1;
      end
      PH_GAP:     ;
      default:    strb.bl_pre = 1'b1;
    endcase
  end

endmodule

// File: rtl/sram_seq_port.sv
module sram_seq_port
  import sram_seq_pkg::*;
#(
  parameter int SENSE_DLY  = 4,
  parameter int SENSE_LEN  = 3,
  parameter int NONOVL_GAP = 2,
  parameter int WRITE_LEN  = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    row_ready,
  output logic    busy,
  output strobe_t strobes
);

  localparam int MAXC = max_of(max_of(SENSE_DLY, SENSE_LEN), max_of(NONOVL_GAP, WRITE_LEN));
  localparam int CW   = cnt_width(MAXC);
  localparam int RW   = CW + 1;
  localparam logic [RW-1:0] RUN_MAX = '1;

  phase_e        ph_q, ph_d;
  logic          op_wr_q;
  logic          accept;
  logic          tm_load;
  logic [CW-1:0] tm_val;
  logic          tm_expired;

  assign accept = req_valid && row_ready && (ph_q == PH_IDLE);
  assign busy   = (ph_q != PH_IDLE);

  always_comb begin
    ph_d    = ph_q;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (ph_q)
      PH_IDLE:    if (accept) ph_d = PH_PREOFF;
      PH_PREOFF: begin
        ph_d    = PH_WORD;
        tm_load = 1'b1;
        tm_val  = op_wr_q ? CW'(WRITE_LEN - 1) : CW'(SENSE_DLY - 1);
      end
      PH_WORD: begin
        if (tm_expired) begin
          tm_load = 1'b1;
          if (op_wr_q) begin
            ph_d   = PH_GAP;
            tm_val = CW'(NONOVL_GAP - 1);
          end else begin
            ph_d   = PH_SENSE;
            tm_val = CW'(SENSE_LEN - 1);
          end
        end
      end
      PH_SENSE:   if (tm_expired) ph_d = PH_RESTART;
      PH_RESTART: ph_d = PH_LATCH;
      PH_LATCH:   ph_d = PH_IDLE;
      PH_GAP:     if (tm_expired) ph_d = PH_IDLE;
      default:    ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      op_wr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) op_wr_q <= req_write;
    end
  end

  seq_tick_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_expired)
  );

  seq_strobe_decode u_decode (
    .phase (ph_q),
    .op_wr (op_wr_q),
    .strb  (strobes)
  );

  // Observation counters at the strobe pins for the timing assertions
  logic [RW-1:0] wl_hi_run_q;  // length of the latest wordline-high run
  logic [RW-1:0] wl_lo_run_q;  // ticks since the wordline last went low
  logic          wl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_hi_run_q <= '0;
      wl_lo_run_q <= '0;
      wl_prev_q   <= 1'b0;
    end else begin
      wl_prev_q <= strobes.wl_en;
      if (strobes.wl_en) begin
        wl_lo_run_q <= '0;
        if (!wl_prev_q)                 wl_hi_run_q <= RW'(1);
        else if (wl_hi_run_q != RUN_MAX) wl_hi_run_q <= wl_hi_run_q + 1'b1;
      end else if (wl_lo_run_q != RUN_MAX) begin
        wl_lo_run_q <= wl_lo_run_q + 1'b1;
      end
    end
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (strobes.bl_pre && strobes.sa_pre && !strobes.wl_en && !strobes.rd_sel
               && !strobes.sa_en && !strobes.wr_en && !strobes.dout_stb)); // R1
  AST_ACCEPT_ROW_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && row_ready)); // R2
  AST_PRE_WL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.bl_pre && strobes.wl_en)); // R3
  AST_PRE_OFF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobes.wl_en) |-> $past(!strobes.bl_pre)); // R3
  AST_SENSE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobes.sa_en) |-> (int'(wl_hi_run_q) >= SENSE_DLY && !strobes.wl_en)); // R4
  AST_SAPRE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.sa_en |-> (!strobes.sa_pre && $past(!strobes.sa_pre))); // R5
  AST_RESTART_BEFORE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobes.dout_stb) |-> ($past(strobes.bl_pre) && !strobes.sa_en)); // R6
  AST_WE_UNDER_WL: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wr_en |-> (strobes.wl_en && !strobes.rd_sel && !strobes.sa_en)); // R7
  AST_WL_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobes.bl_pre) |-> int'(wl_lo_run_q) >= NONOVL_GAP); // R9
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph_q != PH_LATCH && ph_q != PH_GAP) |=> busy); // R10

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_seq_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int SENSE_DLY  = 4,
  parameter int SENSE_LEN  = 3,
  parameter int NONOVL_GAP = 2,
  parameter int WRITE_LEN  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req_valid,
  input  logic [NUM_PORTS-1:0] req_write,
  input  logic [NUM_PORTS-1:0] row_ready,
  output logic [NUM_PORTS-1:0] busy,
  output logic [NUM_PORTS-1:0] bl_pre,
  output logic [NUM_PORTS-1:0] rd_sel,
  output logic [NUM_PORTS-1:0] wl_en,
  output logic [NUM_PORTS-1:0] sa_pre,
  output logic [NUM_PORTS-1:0] sa_en,
  output logic [NUM_PORTS-1:0] wr_en,
  output logic [NUM_PORTS-1:0] dout_stb
);

  initial begin
    AST_PARAM_ORDER: assert (SENSE_DLY >= 1 && SENSE_LEN >= 1 && WRITE_LEN >= 1
                             && NONOVL_GAP >= 1 && SENSE_LEN >= NONOVL_GAP); // R9
    AST_PARAM_PORTS: assert (NUM_PORTS == 1 || NUM_PORTS == 2); // R8
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    strobe_t strb;

    sram_seq_port #(
      .SENSE_DLY  (SENSE_DLY),
      .SENSE_LEN  (SENSE_LEN),
      .NONOVL_GAP (NONOVL_GAP),
      .WRITE_LEN  (WRITE_LEN)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[p]),
      .req_write (req_write[p]),
      .row_ready (row_ready[p]),
      .busy      (busy[p]),
      .strobes   (strb)
    );

    assign bl_pre[p]   = strb.bl_pre;
    assign rd_sel[p]   = strb.rd_sel;
    assign wl_en[p]    = strb.wl_en;
    assign sa_pre[p]   = strb.sa_pre;
    assign sa_en[p]    = strb.sa_en;
    assign wr_en[p]    = strb.wr_en;
    assign dout_stb[p] = strb.dout_stb;
  end

endmodule

// File: tb/tb_sram_strobe_seq.sv
`timescale 1ns/1ps
module tb_sram_strobe_seq;

  localparam int NP = 2;
  localparam int SD = 4;   // wordline-high ticks before sensing
  localparam int SL = 3;   // sense window ticks
  localparam int GP = 2;   // non-overlap gap ticks
  localparam int WL = 3;   // write wordline ticks
  localparam int RD_LEN = SD + SL + 3;
  localparam int WR_LEN = WL + GP + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0, req_write = '0, row_ready = '0;
  logic [NP-1:0] busy, bl_pre, rd_sel, wl_en, sa_pre, sa_en, wr_en, dout_stb;

  always #10 clk = ~clk;  // 50 MHz

  sram_strobe_seq #(.NUM_PORTS(NP), .SENSE_DLY(SD), .SENSE_LEN(SL),
                    .NONOVL_GAP(GP), .WRITE_LEN(WL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .row_ready(row_ready), .busy(busy), .bl_pre(bl_pre), .rd_sel(rd_sel),
    .wl_en(wl_en), .sa_pre(sa_pre), .sa_en(sa_en), .wr_en(wr_en), .dout_stb(dout_stb));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  // word: busy, bl_pre, rd_sel, wl_en, sa_pre, sa_en, wr_en, dout_stb
  logic [7:0] q0_w[$], q1_w[$];
  string      q0_t[$], q1_t[$];
  int run_len[NP], last_run[NP], lo_cnt[NP];
  logic prev_pre[NP];

  function automatic logic [7:0] wd(bit b, bit pr, bit rs, bit w, bit sp, bit se, bit we, bit st);
    return {b, pr, rs, w, sp, se, we, st};
  endfunction

  localparam logic [7:0] IDLE_W = 8'b0100_1000;

  function automatic logic [7:0] port_word(int p);
    return {busy[p], bl_pre[p], rd_sel[p], wl_en[p], sa_pre[p], sa_en[p], wr_en[p], dout_stb[p]};
  endfunction

  task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int p, logic [7:0] w, string tag);
    if (p == 0) begin q0_w.push_back(w); q0_t.push_back(tag); end
    else        begin q1_w.push_back(w); q1_t.push_back(tag); end
  endtask

  function automatic string pick(string ovr, string dflt);
    return (ovr != "") ? ovr : dflt;
  endfunction

  // expected tick sequence of one read (R3 R4 R5 R6)
  task automatic exp_read(int p, string ovr);
    push(p, wd(1,0,0,0,1,0,0,0), pick(ovr, "R3"));
    for (int i = 0; i < SD; i++) push(p, wd(1,0,1,1,0,0,0,0), pick(ovr, (i == 0) ? "R5" : "R4"));
    for (int i = 0; i < SL; i++) push(p, wd(1,0,0,0,0,1,0,0), pick(ovr, "R6"));
    push(p, wd(1,1,0,0,0,0,0,0), pick(ovr, "R6"));
    push(p, wd(1,1,0,0,0,0,0,1), pick(ovr, "R6"));
  endtask

  // expected tick sequence of one write (R7)
  task automatic exp_write(int p, string ovr);
    push(p, wd(1,0,0,0,1,0,0,0), pick(ovr, "R3"));
    for (int i = 0; i < WL; i++) push(p, wd(1,0,0,1,1,0,1,0), pick(ovr, "R7"));
    for (int i = 0; i < GP; i++) push(p, wd(1,0,0,0,1,0,0,0), pick(ovr, "R7"));
  endtask

  task automatic issue(int p, bit wr, string ovr);
    @(posedge clk); #2;
    req_valid[p] = 1'b1; req_write[p] = wr; row_ready[p] = 1'b1;
    @(posedge clk); #1;
    req_valid[p] = 1'b0;
    if (wr) exp_write(p, ovr); else exp_read(p, ovr);
  endtask

  task automatic issue_both(bit wr0, bit wr1);
    @(posedge clk); #2;
    req_valid = 2'b11; req_write = {wr1, wr0}; row_ready = 2'b11;
    @(posedge clk); #1;
    req_valid = 2'b00;
    if (wr0) exp_write(0, "R8"); else exp_read(0, "R8");
    if (wr1) exp_write(1, "R8"); else exp_read(1, "R8");
  endtask

  task automatic wait_idle();
    while (q0_w.size() != 0 || q1_w.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && !done) begin
      for (int p = 0; p < NP; p++) begin
        logic [7:0] exp_w;
        string tg;
        logic [7:0] act;
        act = port_word(p);
        if (p == 0 && q0_w.size() != 0) begin exp_w = q0_w.pop_front(); tg = q0_t.pop_front(); end
        else if (p == 1 && q1_w.size() != 0) begin exp_w = q1_w.pop_front(); tg = q1_t.pop_front(); end
        else begin exp_w = IDLE_W; tg = "R1"; end
        check(tg, act == exp_w, 32'(act), 32'(exp_w));
        // R9: wordline fall to precharge rise gap at the pins
        if (bl_pre[p] && !prev_pre[p])
          check("R9", lo_cnt[p] >= GP, 32'(lo_cnt[p]), 32'(GP));
        if (wl_en[p]) lo_cnt[p] = 0; else lo_cnt[p] = lo_cnt[p] + 1;
        prev_pre[p] = bl_pre[p];
        if (busy[p]) run_len[p] = run_len[p] + 1;
        else if (run_len[p] != 0) begin last_run[p] = run_len[p]; run_len[p] = 0; end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      run_len[p] = 0; last_run[p] = 0; lo_cnt[p] = 0; prev_pre[p] = 1'b1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int p = 0; p < NP; p++)
      check("R1", port_word(p) == IDLE_W, 32'(port_word(p)), 32'(IDLE_W));
    mon_en = 1'b1;

    // R2: request without row-ready is not accepted
    @(posedge clk); #2;
    req_valid[0] = 1'b1; req_write[0] = 1'b0; row_ready[0] = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R2", busy[0] == 1'b0, 32'(busy[0]), 32'd0);
    end
    @(posedge clk); #2;
    row_ready[0] = 1'b1;
    @(posedge clk); #1;
    req_valid[0] = 1'b0;
    exp_read(0, "R2");
    wait_idle();
    check("R6", last_run[0] == RD_LEN, 32'(last_run[0]), 32'(RD_LEN));

    // plain read and write on port 0
    issue(0, 1'b0, "");
    wait_idle();
    issue(0, 1'b1, "");
    wait_idle();
    check("R7", last_run[0] == WR_LEN, 32'(last_run[0]), 32'(WR_LEN));

    // read then write back to back
    issue(0, 1'b0, "");
    while (busy[0]) @(negedge clk);
    issue(0, 1'b1, "");
    wait_idle();

    // R10: requests while busy are ignored
    issue(0, 1'b0, "");
    @(posedge clk); #2;
    req_valid[0] = 1'b1;
    repeat (3) @(posedge clk);
    #2 req_valid[0] = 1'b0;
    wait_idle();
    check("R10", last_run[0] == RD_LEN, 32'(last_run[0]), 32'(RD_LEN));

    // R8: dual-port pairs
    issue_both(1'b0, 1'b0);
    wait_idle();
    check("R8", last_run[1] == RD_LEN, 32'(last_run[1]), 32'(RD_LEN));
    issue_both(1'b0, 1'b1);
    wait_idle();
    check("R8", last_run[1] == WR_LEN, 32'(last_run[1]), 32'(WR_LEN));
    issue_both(1'b1, 1'b0);
    wait_idle();
    // staggered by one tick
    fork
      issue(0, 1'b0, "R8");
      begin @(posedge clk); issue(1, 1'b0, "R8"); end
    join
    wait_idle();
    issue(1, 1'b1, "R8");
    wait_idle();
    check("R8", last_run[0] == RD_LEN, 32'(last_run[0]), 32'(RD_LEN));

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule